// File: doc/BRIEF.md
# Program Counter Sequencer with Return-Address Stack

This block holds the instruction address of a small core and works out the address of the next instruction. Each time the core completes an instruction it raises `step_en`. The block then looks at the current 18-bit instruction word and the zero and carry flags. From these it picks one of several next addresses: the following instruction, a taken conditional branch, an absolute jump, a subroutine entry, or a return address popped from a hardware stack.

The return-address stack is eight entries deep. Calls therefore nest, and the matching returns resume in last-in, first-out order. If a ninth call arrives while the stack is full, the oldest saved address is dropped. A return on an empty stack sends execution to address 0 and latches an underflow indication. The core reads the PC and the stack status directly from the ports.

Top module: `pcseq_top`

## Requirements
- R1: After reset the PC is 0, the stack level is 0, the empty flag is 1, and the full and underflow flags are 0.
- R2: When `step_en` is low, the PC, the stack level and the stack contents stay unchanged, whatever the instruction word.
- R3: An instruction word that is not a branch, jump, call or return advances the PC by 1, and address 4095 wraps to 0. This includes the miscellaneous form `insn[17:11]`=1111110 with a function field `insn[10:8]` other than 000.
- R4: A branch has `insn[17:12]`=111110. Its condition field `insn[11:10]` selects the test: 00 branches when Z=1, 01 when Z=0, 10 when C=1, and 11 when C=0.
- R5: A taken branch loads PC+1 plus the two's-complement displacement in `insn[7:0]`, modulo 4096. A branch that is not taken loads PC+1.
- R6: A jump has `insn[17:13]`=11110 and `insn[12]`=0. It loads the PC with `insn[11:0]`.
- R7: A call has `insn[17:13]`=11110 and `insn[12]`=1. It pushes PC+1 (modulo 4096) onto the stack and loads the PC with `insn[11:0]`.
- R8: A return has `insn[17:11]`=1111110 and `insn[10:8]`=000. It pops the most recently pushed address into the PC, so nested calls unwind in reverse order.
- R9: The stack holds 8 entries. A push onto a full stack discards the oldest entry and leaves the level at 8.
- R10: A return on an empty stack loads PC 0 and leaves the level at 0. It also sets the underflow flag, which stays set until reset.
- R11: `stk_level` reports the number of stored entries. `stk_full` is 1 exactly when the level is 8, and `stk_empty` is 1 exactly when the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance to the next instruction this cycle |
| insn | input | 18 | Current instruction word |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| pc | output | 12 | Current instruction address |
| stk_level | output | 4 | Number of return addresses held |
| stk_full | output | 1 | Stack holds 8 entries |
| stk_empty | output | 1 | Stack holds no entries |
| stk_underflow | output | 1 | A return found the stack empty since reset |

## Verification
Every branch condition code is driven against all four combinations of Z and C. Positive displacements are used on some of these runs and negative ones on others. This separates a swapped condition or an inverted test from an error in the offset. The offset error covers both sign extension and the use of the branch's own address instead of the next one.

Jumps and branches near address 4095 show whether the PC arithmetic wraps. An eight-deep nest of calls followed by eight returns shows whether the stack is last-in, first-out. A nine-deep nest, unwound to one return past empty, tells apart three faults: dropping the newest entry instead of the oldest, a level counter that does not saturate, and underflow handling. Words driven with `step_en` low confirm that nothing moves.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  localparam int PC_W   = 12;
  localparam int INSN_W = 18;
  localparam int DISP_W = 8;

  typedef enum logic [2:0] {
    OP_SEQ  = 3'd0,
    OP_BR   = 3'd1,
    OP_JMP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4
  } op_e;

  // Address of the following instruction, wrapping at the top of the space.
  function automatic logic [PC_W-1:0] pc_plus_one(input logic [PC_W-1:0] a);
    return a + {{(PC_W-1){1'b0}}, 1'b1};
  endfunction

  // Relative target: sign-extend the displacement and add it to the base.
  function automatic logic [PC_W-1:0] rel_target(input logic [PC_W-1:0] base,
                                                 input logic [DISP_W-1:0] disp);
    logic [PC_W-1:0] ext;
    ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
    return base + ext;
  endfunction

  // Condition test selected by the two-bit code.
  function automatic logic cond_hit(input logic [1:0] cc, input logic z, input logic c);
    case (cc)
      2'b00:   return z;
      2'b01:   return !z;
      2'b10:   return c;
      default: return !c;
    endcase
  endfunction

endpackage

// File: rtl/pcseq_decode.sv
module pcseq_decode
  import pcseq_pkg::*;
#(
  parameter int IW = INSN_W,
  parameter int AW = PC_W,
  parameter int DW = DISP_W
) (
  input  logic [IW-1:0] insn,
  output op_e           op,
  output logic [1:0]    cc,
  output logic [DW-1:0] disp,
  output logic [AW-1:0] target
);

  localparam logic [5:0] BR_PFX   = 6'b111110;
  localparam logic [4:0] JMP_PFX  = 5'b11110;
  localparam logic [6:0] MISC_PFX = 7'b1111110;
  localparam logic [2:0] RET_FN   = 3'b000;

  logic is_br, is_jf, is_ret;

  assign is_br  = (insn[IW-1 -: 6] == BR_PFX);
  assign is_jf  = (insn[IW-1 -: 5] == JMP_PFX);
  assign is_ret = (insn[IW-1 -: 7] == MISC_PFX) && (insn[IW-8 -: 3] == RET_FN);

  assign cc     = insn[IW-7 -: 2];
  assign disp   = insn[DW-1:0];
  assign target = insn[AW-1:0];

  always_comb begin
    if (is_br)                     op = OP_BR;
    else if (is_jf && !insn[AW])   op = OP_JMP;
    else if (is_jf &&  insn[AW])   op = OP_CALL;
    else if (is_ret)               op = OP_RET;
    else                           op = OP_SEQ;
  end

endmodule

// File: rtl/pcseq_ras.sv
module pcseq_ras #(
  parameter int AW    = 12,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic [AW-1:0]    din,
  output logic [AW-1:0]    dout,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             underflow
);

  // Circular storage: a push past the depth overwrites the oldest slot.
  logic [AW-1:0]    slot [DEPTH];
  logic [PTR_W-1:0] top;
  logic [PTR_W-1:0] wr_idx;
  logic [LVL_W-1:0] cnt;
  logic             uf_q;

  assign wr_idx = top + {{(PTR_W-1){1'b0}}, 1'b1};
  assign full   = (cnt == LVL_W'(DEPTH));
  assign empty  = (cnt == '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot[i] <= '0;
      else if (push && (wr_idx == PTR_W'(i)))
        slot[i] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top  <= '0;
      cnt  <= '0;
      uf_q <= 1'b0;
    end else if (push) begin
      top <= wr_idx;
      if (!full) cnt <= cnt + 1'b1;
    end else if (pop) begin
      if (empty) begin
        uf_q <= 1'b1;
      end else begin
        top <= top - 1'b1;
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign dout      = empty ? '0 : slot[top];
  assign level     = cnt;
  assign underflow = uf_q;

endmodule

// File: rtl/pcseq_next.sv
module pcseq_next
  import pcseq_pkg::*;
#(
  parameter int AW = PC_W,
  parameter int DW = DISP_W
) (
  input  logic          step_en,
  input  op_e           op,
  input  logic [1:0]    cc,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] target,
  input  logic          flag_z,
  input  logic          flag_c,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] ret_addr,
  output logic [AW-1:0] pc_nxt,
  output logic [AW-1:0] link_addr,
  output logic          push,
  output logic          pop,
  output logic          taken
);

  logic [AW-1:0] seq_addr;
  logic [AW-1:0] sel;

  assign seq_addr  = pc_plus_one(pc);
  assign link_addr = seq_addr;
  assign taken     = (op == OP_BR) && cond_hit(cc, flag_z, flag_c);

  always_comb begin
    sel = seq_addr;
    unique case (op)
      OP_BR:   sel = taken ? rel_target(seq_addr, disp) : seq_addr;
      OP_JMP:  sel = target;
      OP_CALL: sel = target;
      OP_RET:  sel = ret_addr;
      default: sel = seq_addr;
    endcase
  end

  assign pc_nxt = step_en ? sel : pc;
  assign push   = step_en && (op == OP_CALL);
  assign pop    = step_en && (op == OP_RET);

endmodule

// File: rtl/pcseq_top.sv
module pcseq_top
  import pcseq_pkg::*;
#(
  parameter int AW    = PC_W,
  parameter int IW    = INSN_W,
  parameter int DW    = DISP_W,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic [IW-1:0]    insn,
  input  logic             flag_z,
  input  logic             flag_c,
  output logic [AW-1:0]    pc,
  output logic [LVL_W-1:0] stk_level,
  output logic             stk_full,
  output logic             stk_empty,
  output logic             stk_underflow
);

  // Named internal events, visible to the bound checker.
  op_e           dec_op;
  logic [1:0]    dec_cc;
  logic [DW-1:0] dec_disp;
  logic [AW-1:0] dec_target;
  logic [AW-1:0] ret_addr;
  logic [AW-1:0] link_addr;
  logic [AW-1:0] pc_nxt;
  logic          ev_push;
  logic          ev_pop;
  logic          ev_taken;
  logic [AW-1:0] pc_q;

  pcseq_decode #(.IW(IW), .AW(AW), .DW(DW)) u_dec (
    .insn   (insn),
    .op     (dec_op),
    .cc     (dec_cc),
    .disp   (dec_disp),
    .target (dec_target)
  );

  pcseq_next #(.AW(AW), .DW(DW)) u_nxt (
    .step_en   (step_en),
    .op        (dec_op),
    .cc        (dec_cc),
    .disp      (dec_disp),
    .target    (dec_target),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .pc        (pc_q),
    .ret_addr  (ret_addr),
    .pc_nxt    (pc_nxt),
    .link_addr (link_addr),
    .push      (ev_push),
    .pop       (ev_pop),
    .taken     (ev_taken)
  );

  pcseq_ras #(.AW(AW), .DEPTH(DEPTH)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .pop       (ev_pop),
    .din       (link_addr),
    .dout      (ret_addr),
    .level     (stk_level),
    .full      (stk_full),
    .empty     (stk_empty),
    .underflow (stk_underflow)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
  end

  assign pc = pc_q;

endmodule

// File: rtl/pcseq_chk.sv
module pcseq_chk
  import pcseq_pkg::*;
#(
  parameter int AW    = PC_W,
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_en,
  input op_e              op,
  input logic             taken,
  input logic [AW-1:0]    target,
  input logic [AW-1:0]    pc,
  input logic [LVL_W-1:0] level,
  input logic             underflow
);

  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(pc) && $stable(level)));

  assert_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == OP_SEQ) |=> (pc == $past(pc) + ONE));

  assert_not_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == OP_BR && !taken) |=> (pc == $past(pc) + ONE));

  assert_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == OP_JMP) |=> (pc == $past(target)));

  assert_call_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == OP_CALL && level != LVL_W'(DEPTH)) |=> (level == $past(level) + 1'b1));

  assert_full_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == OP_CALL && level == LVL_W'(DEPTH)) |=> (level == LVL_W'(DEPTH)));

  assert_level_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  assert_underflow_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && op == OP_RET && level == '0) |=> (pc == '0 && underflow));

endmodule

bind pcseq_top pcseq_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .step_en   (step_en),
  .op        (dec_op),
  .taken     (ev_taken),
  .target    (dec_target),
  .pc        (pc),
  .level     (stk_level),
  .underflow (stk_underflow)
);

// File: tb/sim_pcseq_top.sv
`timescale 1ns/1ps
module sim_pcseq_top;

  localparam int DEPTH = 8;

  typedef struct {
    logic [11:0] pc;
    int          lvl;
    logic        uf;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0;
  logic [17:0] insn = '0;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic [11:0] pc;
  logic [3:0]  stk_level;
  logic        stk_full, stk_empty, stk_underflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  exp_t        sb[$];
  logic [11:0] m_pc = '0;
  logic [11:0] m_stk[$];
  logic        m_uf = 1'b0;

  always #10 clk = ~clk;

  pcseq_top u0 (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .insn(insn),
    .flag_z(flag_z), .flag_c(flag_c), .pc(pc), .stk_level(stk_level),
    .stk_full(stk_full), .stk_empty(stk_empty), .stk_underflow(stk_underflow)
  );

  function automatic logic [17:0] w_br(input logic [1:0] cc, input logic [7:0] d);
    return {6'b111110, cc, 2'b00, d};
  endfunction
  function automatic logic [17:0] w_jmp(input logic call, input logic [11:0] a);
    return {5'b11110, call, a};
  endfunction
  function automatic logic [17:0] w_misc(input logic [2:0] fn);
    return {7'b1111110, fn, 8'h00};
  endfunction

  // Driver: applies one word at a falling edge and predicts the outcome.
  task automatic drive(input logic [17:0] w, input logic z, input logic c,
                       input logic en, input string tag);
    exp_t e;
    logic [11:0] nxt;
    logic        t;
    @(negedge clk);
    insn = w; flag_z = z; flag_c = c; step_en = en;
    nxt = m_pc + 12'd1;
    if (en) begin
      casez (w)
        18'b111110_??_??_????????: begin
          case (w[11:10])
            2'b00: t = z;
            2'b01: t = ~z;
            2'b10: t = c;
            default: t = ~c;
          endcase
          if (t) nxt = 12'(int'(m_pc) + 1 + int'($signed(w[7:0])));
        end
        18'b11110_?_????????????: begin
          if (w[12]) begin
            if (m_stk.size() == DEPTH) void'(m_stk.pop_front());
            m_stk.push_back(m_pc + 12'd1);
          end
          nxt = w[11:0];
        end
        18'b1111110_000_????????: begin
          if (m_stk.size() == 0) begin
            nxt = '0; m_uf = 1'b1;
          end else nxt = m_stk.pop_back();
        end
        default: ;
      endcase
      m_pc = nxt;
    end
    e.pc = m_pc; e.lvl = m_stk.size(); e.uf = m_uf; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compares each prediction just after the edge that commits it.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (pc !== e.pc || int'(stk_level) != e.lvl || stk_underflow !== e.uf ||
            stk_full !== (e.lvl == DEPTH) || stk_empty !== (e.lvl == 0)) begin
          failures++;
          $display("FAIL %s: pc=%h lvl=%0d uf=%b full=%b empty=%b, expected pc=%h lvl=%0d uf=%b",
                   e.tag, pc, stk_level, stk_underflow, stk_full, stk_empty, e.pc, e.lvl, e.uf);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pc !== 12'h000 || stk_level !== 4'd0 || stk_underflow !== 1'b0 ||
        stk_empty !== 1'b1 || stk_full !== 1'b0) begin
      failures++;
      $display("FAIL R1: pc=%h lvl=%0d uf=%b, expected pc=000 lvl=0 uf=0", pc, stk_level, stk_underflow);
    end
    rst_n = 1'b1;

    drive(18'h00000, 0, 0, 1, "R3 plain step");
    drive(18'h12345, 1, 1, 1, "R3 plain step");
    drive(w_misc(3'b010), 0, 0, 1, "R3 misc non-return");
    drive(w_jmp(1'b0, 12'h777), 0, 0, 0, "R2 jump held");
    drive(w_jmp(1'b1, 12'h777), 0, 0, 0, "R2 call held");
    drive(w_jmp(1'b0, 12'h100), 0, 0, 1, "R6 jump");

    for (int cc = 0; cc < 4; cc++) begin
      for (int f = 0; f < 4; f++) begin
        drive(w_br(2'(cc), (f[0] ? 8'hFD : 8'h05)), f[1], f[0], 1, "R4 R5 branch cond");
      end
    end

    drive(w_jmp(1'b0, 12'hFFE), 0, 0, 1, "R6 jump high");
    drive(18'h00000, 0, 0, 1, "R3 step to top");
    drive(18'h00000, 0, 0, 1, "R3 wrap to zero");
    drive(w_jmp(1'b0, 12'hFFD), 0, 0, 1, "R6 jump high");
    drive(w_br(2'b00, 8'h05), 1, 0, 1, "R5 branch wraps forward");
    drive(w_br(2'b11, 8'hF0), 0, 0, 1, "R5 branch wraps backward");

    for (int i = 0; i < 8; i++)
      drive(w_jmp(1'b1, 12'(12'h200 + i * 16)), 0, 0, 1, "R7 R11 nested call");
    drive(w_misc(3'b000), 0, 0, 0, "R2 return held");
    for (int i = 0; i < 8; i++)
      drive(w_misc(3'b000), 0, 0, 1, "R8 nested return");

    for (int i = 0; i < 9; i++)
      drive(w_jmp(1'b1, 12'(12'h400 + i * 32)), 0, 0, 1, "R9 call past depth");
    for (int i = 0; i < 8; i++)
      drive(w_misc(3'b000), 0, 0, 1, "R9 return keeps newest");
    drive(w_misc(3'b000), 0, 0, 1, "R10 return on empty");
    drive(18'h00000, 0, 0, 1, "R10 underflow stays");
    drive(w_jmp(1'b1, 12'h050), 0, 0, 1, "R10 R7 call after underflow");

    @(negedge clk);
    step_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule